// File: doc/BRIEF.md
# Return Address Prediction Stack

This block predicts where subroutine returns will go in a RISC fetch pipeline. Each cycle it looks at one decoded instruction and its PC. A call, or a register-indirect jump that writes the outgoing link register, stores a return address of PC + 8. The extra 4 bytes skip the delay slot. A jump that matches one of the two standard return forms reads the top entry as its predicted target and removes that entry.

The entries sit in a circular buffer with a top pointer and an occupancy count. When calls nest deeper than the buffer holds, the oldest entries are overwritten without any stall, so the returns that needed them get stale targets. The block records the target of the most recent prediction. When the true target of that return resolves and does not match, the block raises a one-cycle mispredict pulse and gives fetch the correct address to redirect to.

Top module: `ras_predictor`

## Requirements
- R1: After synchronous reset, mispredict is low, every entry holds zero and the stack is empty. A return presented right after reset has pred_hit low and pred_target 0.
- R2: A valid instruction with dec_is_call high pushes dec_pc + 8.
- R3: A valid register-indirect jump (dec_is_jmpl) with dec_rd = 15 pushes dec_pc + 8.
- R4: A valid jump with dec_rd = 0, dec_rs1 = 15, an immediate operand (dec_use_imm = 1) and dec_imm = 8 is a return. In the same cycle it drives pred_valid high and pred_target to the top entry, and it pops that entry, so entries come out in last-in first-out order.
- R5: A jump of the same form as R4 but with dec_rs1 = 31 is also a return, with the same prediction and pop.
- R6: Any jump outside the return forms, and any instruction presented with dec_valid low, leaves pred_valid low and does not change the stack. This covers a different source register, an immediate other than 8, a register operand, and a destination other than 0 or 15. A non-return jump with dec_rd = 15 still pushes, as R3 states.
- R7: The stack holds 8 entries. A push into a full stack overwrites the oldest entry. After ten pushes, eight returns give back the last eight addresses, newest first.
- R8: A return seen when the stack is empty still pops and wraps the top pointer. It outputs that slot's stale contents with pred_hit low, and the occupancy stays at zero.
- R9: A return form with dec_rd = 15 first predicts from the top entry and pops it. In the same cycle it then pushes dec_pc + 8 into the slot it just freed, so the depth does not change.
- R10: In the cycle after rsv_valid is high, mispredict is high for exactly that one cycle when rsv_target differs from the most recently recorded prediction, and redirect_pc carries rsv_target. A matching target leaves mispredict low. A misprediction does not change the stack contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | Decoded instruction present |
| dec_is_call | input | 1 | Instruction is a PC-relative call |
| dec_is_jmpl | input | 1 | Instruction is a register-indirect jump and link |
| dec_rd | input | 5 | Destination register number |
| dec_rs1 | input | 5 | First source register number |
| dec_use_imm | input | 1 | Second operand is the immediate |
| dec_imm | input | 13 | Sign-extended immediate field |
| dec_pc | input | 32 | Address of the instruction |
| pred_valid | output | 1 | Instruction is recognised as a return |
| pred_hit | output | 1 | Prediction comes from a live entry |
| pred_target | output | 32 | Predicted return target |
| rsv_valid | input | 1 | Resolved target of the last predicted return is available |
| rsv_target | input | 32 | Resolved return target |
| mispredict | output | 1 | One-cycle misprediction pulse |
| redirect_pc | output | 32 | Correct fetch address during mispredict |

## Verification
The checker tests several rules on every cycle. After reset, nothing is flagged. A call is followed by a prediction of its PC + 8 if the next instruction is a return. An empty stack stays empty across a return that does not push. A hit is never raised without a return. Every mispredict pulse follows a resolve and carries the resolved address. Other behaviour needs directed sequences in the bench: last-in first-out ordering across both return forms, non-return jumps that leave the stack alone, wrap-around overflow with stale predictions after the stack drains, the combined pop-then-push, and the stack surviving a misprediction.

// File: rtl/ras_pkg.sv
package ras_pkg;
    localparam int          REG_W     = 5;
    localparam int          IMM_W     = 13;
    localparam logic [4:0]  REG_ZERO  = 5'd0;
    localparam logic [4:0]  REG_OLINK = 5'd15;
    localparam logic [4:0]  REG_ILINK = 5'd31;
    localparam int          LINK_OFS  = 8;

    typedef enum logic [1:0] {
        STK_IDLE    = 2'd0,
        STK_PUSH    = 2'd1,
        STK_POP     = 2'd2,
        STK_POPPUSH = 2'd3
    } stk_op_e;

    function automatic logic is_link_src(input logic [REG_W-1:0] r);
        return (r == REG_OLINK) || (r == REG_ILINK);
    endfunction
endpackage

// File: rtl/ras_decode.sv
module ras_decode
    import ras_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                 dec_valid,
    input  logic                 dec_is_call,
    input  logic                 dec_is_jmpl,
    input  logic [REG_W-1:0]     dec_rd,
    input  logic [REG_W-1:0]     dec_rs1,
    input  logic                 dec_use_imm,
    input  logic [IMM_W-1:0]     dec_imm,
    input  logic [ADDR_W-1:0]    dec_pc,
    output stk_op_e              op,
    output logic [ADDR_W-1:0]    link_addr
);
    logic writes_link;
    logic ret_form;
    logic do_push;
    logic do_pop;

    always_comb begin
        writes_link = dec_is_jmpl && (dec_rd == REG_OLINK);
        ret_form    = dec_is_jmpl && dec_use_imm
                      && (dec_imm == IMM_W'(LINK_OFS))
                      && is_link_src(dec_rs1)
                      && ((dec_rd == REG_ZERO) || (dec_rd == REG_OLINK));
        do_push     = dec_valid && (dec_is_call || writes_link);
        do_pop      = dec_valid && ret_form;
        unique case ({do_pop, do_push})
            2'b01:   op = STK_PUSH;
            2'b10:   op = STK_POP;
            2'b11:   op = STK_POPPUSH;
            default: op = STK_IDLE;
        endcase
        link_addr = dec_pc + ADDR_W'(LINK_OFS);
    end
endmodule

// File: rtl/ras_stack.sv
module ras_stack
    import ras_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  stk_op_e           op,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] top_addr,
    output logic              nonempty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    logic [ADDR_W-1:0] slot [DEPTH];
    logic [PTR_W-1:0]  tos;
    logic [CNT_W-1:0]  occ;
    logic [PTR_W-1:0]  tos_up;
    logic [PTR_W-1:0]  tos_dn;

    always_comb begin
        tos_up   = (tos == PTR_LAST) ? '0 : tos + 1'b1;
        tos_dn   = (tos == '0) ? PTR_LAST : tos - 1'b1;
        top_addr = slot[tos];
        nonempty = (occ != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tos <= '0;
            occ <= '0;
            for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
        end else begin
            unique case (op)
                STK_PUSH: begin
                    slot[tos_up] <= wr_addr;
                    tos          <= tos_up;
                    if (occ != CNT_FULL) occ <= occ + 1'b1;
                end
                STK_POP: begin
                    tos <= tos_dn;
                    if (occ != '0) occ <= occ - 1'b1;
                end
                STK_POPPUSH: begin
                    slot[tos] <= wr_addr;
                    if (occ == '0) occ <= CNT_W'(1);
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ras_resolve.sv
module ras_resolve #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rec_en,
    input  logic [ADDR_W-1:0] rec_addr,
    input  logic              rsv_valid,
    input  logic [ADDR_W-1:0] rsv_target,
    output logic              mispredict,
    output logic [ADDR_W-1:0] redirect_pc
);
    logic [ADDR_W-1:0] last_pred;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_pred   <= '0;
            mispredict  <= 1'b0;
            redirect_pc <= '0;
        end else begin
            if (rec_en) last_pred <= rec_addr;
            mispredict <= rsv_valid && (rsv_target != last_pred);
            if (rsv_valid) redirect_pc <= rsv_target;
        end
    end
endmodule

// File: rtl/ras_predictor.sv
module ras_predictor
    import ras_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dec_valid,
    input  logic              dec_is_call,
    input  logic              dec_is_jmpl,
    input  logic [4:0]        dec_rd,
    input  logic [4:0]        dec_rs1,
    input  logic              dec_use_imm,
    input  logic [12:0]       dec_imm,
    input  logic [ADDR_W-1:0] dec_pc,
    output logic              pred_valid,
    output logic              pred_hit,
    output logic [ADDR_W-1:0] pred_target,
    input  logic              rsv_valid,
    input  logic [ADDR_W-1:0] rsv_target,
    output logic              mispredict,
    output logic [ADDR_W-1:0] redirect_pc
);
    stk_op_e           op;
    logic [ADDR_W-1:0] link_addr;
    logic [ADDR_W-1:0] top_addr;
    logic              nonempty;

    ras_decode #(.ADDR_W(ADDR_W)) u_decode (
        .dec_valid   (dec_valid),
        .dec_is_call (dec_is_call),
        .dec_is_jmpl (dec_is_jmpl),
        .dec_rd      (dec_rd),
        .dec_rs1     (dec_rs1),
        .dec_use_imm (dec_use_imm),
        .dec_imm     (dec_imm),
        .dec_pc      (dec_pc),
        .op          (op),
        .link_addr   (link_addr)
    );

    ras_stack #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_stack (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .wr_addr  (link_addr),
        .top_addr (top_addr),
        .nonempty (nonempty)
    );

    always_comb begin
        pred_valid  = (op == STK_POP) || (op == STK_POPPUSH);
        pred_hit    = pred_valid && nonempty;
        pred_target = top_addr;
    end

    ras_resolve #(.ADDR_W(ADDR_W)) u_resolve (
        .clk         (clk),
        .rst         (rst),
        .rec_en      (pred_valid),
        .rec_addr    (top_addr),
        .rsv_valid   (rsv_valid),
        .rsv_target  (rsv_target),
        .mispredict  (mispredict),
        .redirect_pc (redirect_pc)
    );
endmodule

// File: rtl/ras_predictor_chk.sv
module ras_predictor_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              dec_valid,
    input logic              dec_is_call,
    input logic [4:0]        dec_rd,
    input logic [ADDR_W-1:0] dec_pc,
    input logic              pred_valid,
    input logic              pred_hit,
    input logic [ADDR_W-1:0] pred_target,
    input logic              rsv_valid,
    input logic [ADDR_W-1:0] rsv_target,
    input logic              mispredict,
    input logic [ADDR_W-1:0] redirect_pc
);
    AST_QUIET_AFTER_RESET: assert property (@(posedge clk)
        $past(rst) |-> (!mispredict && !pred_hit)); // R1

    AST_CALL_THEN_RETURN: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_is_call) |=>
            (!pred_valid || (pred_hit && pred_target == $past(dec_pc) + ADDR_W'(8)))); // R2

    AST_HIT_NEEDS_RETURN: assert property (@(posedge clk) disable iff (rst)
        pred_hit |-> pred_valid); // R8

    AST_EMPTY_STAYS_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (pred_valid && !pred_hit && dec_rd != 5'd15) |=> (!pred_valid || !pred_hit)); // R8

    AST_MISPREDICT_CAUSE: assert property (@(posedge clk) disable iff (rst)
        mispredict |-> $past(rsv_valid)); // R10

    AST_REDIRECT_TARGET: assert property (@(posedge clk) disable iff (rst)
        mispredict |-> (redirect_pc == $past(rsv_target))); // R10
endmodule

bind ras_predictor ras_predictor_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .dec_valid   (dec_valid),
    .dec_is_call (dec_is_call),
    .dec_rd      (dec_rd),
    .dec_pc      (dec_pc),
    .pred_valid  (pred_valid),
    .pred_hit    (pred_hit),
    .pred_target (pred_target),
    .rsv_valid   (rsv_valid),
    .rsv_target  (rsv_target),
    .mispredict  (mispredict),
    .redirect_pc (redirect_pc)
);

// File: tb/ras_predictor_bench.sv
`timescale 1ns/1ps
module ras_predictor_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dec_valid = 1'b0, dec_is_call = 1'b0, dec_is_jmpl = 1'b0, dec_use_imm = 1'b0;
    logic [4:0]  dec_rd = '0, dec_rs1 = '0;
    logic [12:0] dec_imm = '0;
    logic [31:0] dec_pc = '0;
    logic        pred_valid, pred_hit, mispredict;
    logic [31:0] pred_target, redirect_pc;
    logic        rsv_valid = 1'b0;
    logic [31:0] rsv_target = '0;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    ras_predictor u_ras_predictor (
        .clk(clk), .rst(rst), .dec_valid(dec_valid), .dec_is_call(dec_is_call),
        .dec_is_jmpl(dec_is_jmpl), .dec_rd(dec_rd), .dec_rs1(dec_rs1),
        .dec_use_imm(dec_use_imm), .dec_imm(dec_imm), .dec_pc(dec_pc),
        .pred_valid(pred_valid), .pred_hit(pred_hit), .pred_target(pred_target),
        .rsv_valid(rsv_valid), .rsv_target(rsv_target),
        .mispredict(mispredict), .redirect_pc(redirect_pc)
    );

    // ops: 0 idle, 1 call, 2 jmpl writing r15 (not return), 3 return via r15,
    // 4 return via r31, 5 r31 with imm 12, 6 return via r31 writing r15, 7 rs1=r3 imm 8
    // vector: {op[2:0], pc[15:0], exp_valid, exp_hit, exp_target[15:0]}
    localparam int NV = 12;
    localparam logic [36:0] VEC [NV] = '{
        {3'd1, 16'h0100, 1'b0, 1'b0, 16'h0000},   // R2
        {3'd1, 16'h0200, 1'b0, 1'b0, 16'h0000},   // R2
        {3'd2, 16'h0300, 1'b0, 1'b0, 16'h0000},   // R3
        {3'd5, 16'h0400, 1'b0, 1'b0, 16'h0000},   // R6
        {3'd7, 16'h0410, 1'b0, 1'b0, 16'h0000},   // R6
        {3'd3, 16'h0500, 1'b1, 1'b1, 16'h0308},   // R4
        {3'd4, 16'h0510, 1'b1, 1'b1, 16'h0208},   // R5
        {3'd1, 16'h0600, 1'b0, 1'b0, 16'h0000},   // R2
        {3'd6, 16'h0700, 1'b1, 1'b1, 16'h0608},   // R9
        {3'd4, 16'h0710, 1'b1, 1'b1, 16'h0708},   // R9
        {3'd3, 16'h0720, 1'b1, 1'b1, 16'h0108},   // R4
        {3'd3, 16'h0730, 1'b1, 1'b0, 16'h0000}    // R8
    };

    task automatic check(input string req, input logic ok, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_op(input logic [2:0] op, input logic [15:0] pc);
        dec_valid = (op != 3'd0); dec_is_call = 1'b0; dec_is_jmpl = 1'b0;
        dec_rd = 5'd0; dec_rs1 = 5'd0; dec_use_imm = 1'b1; dec_imm = 13'd0;
        dec_pc = {16'h0000, pc};
        case (op)
            3'd1: dec_is_call = 1'b1;
            3'd2: begin dec_is_jmpl = 1'b1; dec_rd = 5'd15; dec_rs1 = 5'd5; end
            3'd3: begin dec_is_jmpl = 1'b1; dec_rs1 = 5'd15; dec_imm = 13'd8; end
            3'd4: begin dec_is_jmpl = 1'b1; dec_rs1 = 5'd31; dec_imm = 13'd8; end
            3'd5: begin dec_is_jmpl = 1'b1; dec_rs1 = 5'd31; dec_imm = 13'd12; end
            3'd6: begin dec_is_jmpl = 1'b1; dec_rd = 5'd15; dec_rs1 = 5'd31; dec_imm = 13'd8; end
            3'd7: begin dec_is_jmpl = 1'b1; dec_rs1 = 5'd3; dec_imm = 13'd8; end
            default: ;
        endcase
    endtask

    task automatic step(input logic [2:0] op, input logic [15:0] pc);
        @(negedge clk);
        set_op(op, pc);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; set_op(3'd0, 16'h0); rsv_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic expect_ret(input string req, input logic hit, input logic [31:0] tgt);
        check(req, pred_valid === 1'b1, {31'h0, pred_valid}, 32'h1);
        check(req, pred_hit === hit, {31'h0, pred_hit}, {31'h0, hit});
        check(req, pred_target === tgt, pred_target, tgt);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            fails++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: reset state
        #1;
        check("R1", mispredict === 1'b0, {31'h0, mispredict}, 32'h0);
        step(3'd4, 16'h0050);
        expect_ret("R1", 1'b0, 32'h0);
        do_reset();

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][36:34], VEC[i][33:18]);
            check("R4/R5/R6 valid", pred_valid === VEC[i][17], {31'h0, pred_valid}, {31'h0, VEC[i][17]});
            if (VEC[i][17]) begin
                check("R4/R5/R9 hit", pred_hit === VEC[i][16], {31'h0, pred_hit}, {31'h0, VEC[i][16]});
                check("R4/R5/R9 target", pred_target === {16'h0, VEC[i][15:0]}, pred_target, {16'h0, VEC[i][15:0]});
            end
        end

        // R6: invalid instructions and register-operand jumps leave stack alone
        do_reset();
        step(3'd1, 16'h0800);
        step(3'd1, 16'h0900); dec_valid = 1'b0; #0.1;
        check("R6 invalid", pred_valid === 1'b0, {31'h0, pred_valid}, 32'h0);
        step(3'd4, 16'h0a00); dec_valid = 1'b0; #0.1;
        check("R6 invalid ret", pred_valid === 1'b0, {31'h0, pred_valid}, 32'h0);
        step(3'd4, 16'h0a10); dec_use_imm = 1'b0; #0.1;
        check("R6 reg operand", pred_valid === 1'b0, {31'h0, pred_valid}, 32'h0);
        step(3'd4, 16'h0a20); dec_rd = 5'd7; #0.1;
        check("R6 other rd", pred_valid === 1'b0, {31'h0, pred_valid}, 32'h0);
        step(3'd4, 16'h0a30);
        expect_ret("R6 top intact", 1'b1, 32'h0808);

        // R7: overflow wraps and drops the oldest two
        do_reset();
        for (int i = 0; i < 10; i++) step(3'd1, 16'h1000 + 16'(i * 16));
        for (int j = 0; j < 8; j++) begin
            step(3'd3, 16'h2000);
            expect_ret("R7", 1'b1, 32'h1008 + 32'((9 - j) * 16));
        end
        // R8: empty returns output stale wrapped slots
        step(3'd4, 16'h2000);
        expect_ret("R8", 1'b0, 32'h1098);
        step(3'd4, 16'h2000);
        expect_ret("R8", 1'b0, 32'h1088);

        // R10: mispredict behaviour
        do_reset();
        step(3'd1, 16'h1000);
        step(3'd1, 16'h1100);
        step(3'd3, 16'h1200);
        expect_ret("R10 setup", 1'b1, 32'h1108);
        step(3'd0, 16'h0); rsv_valid = 1'b1; rsv_target = 32'h1108;
        @(negedge clk); rsv_valid = 1'b0; #1;
        check("R10 match", mispredict === 1'b0, {31'h0, mispredict}, 32'h0);
        @(negedge clk); rsv_valid = 1'b1; rsv_target = 32'h2000;
        @(negedge clk); rsv_valid = 1'b0; #1;
        check("R10 flag", mispredict === 1'b1, {31'h0, mispredict}, 32'h1);
        check("R10 redirect", redirect_pc === 32'h2000, redirect_pc, 32'h2000);
        @(negedge clk); #1;
        check("R10 one cycle", mispredict === 1'b0, {31'h0, mispredict}, 32'h0);
        step(3'd4, 16'h1300);
        expect_ret("R10 stack kept", 1'b1, 32'h1008);

        step(3'd0, 16'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule